// File: doc/BRIEF.md
# TDC Register and Readout Interface

This block is the bus-slave front end of a time-to-digital converter board. The bus has a 24-bit address, 32-bit data, single-cycle read and write strobes, and an acknowledge. The board answers only when the top twelve address bits equal the setting of three 4-bit selector switches.

Inside that 4 KiB board window the block does four things:
- It holds the 24-bit time-window register.
- It turns two bits of a control write into one-clock reset pulses, one for the converter and one for its time counter.
- It reports how many events wait in the data FIFO.
- It returns the switch setting and two fixed test patterns.

Any read in the upper half of the window hands back the FIFO head word and pops it. The FIFO is outside the block and is reached through a show-ahead read port. A pop takes precedence over the FIFO writer, which gets a grant signal that drops while a pop is under way.

Top module: `tdc_regif`

## Requirements
- R1: The board is selected only when addr[23:20]==sw_hi, addr[19:16]==sw_mid and addr[15:12]==sw_lo. An unselected access gives no ack, no pop, no pulse and no register change.
- R2: A selected strobe is acknowledged by bus_ack one clock later, for exactly one clock. bus_rdata is valid in that same clock and is 0 for writes.
- R3: A write to offset 0x000 loads bus_wdata[23:0] into the window register, and the new value shows on win_value on the next clock. A write to any other offset changes nothing.
- R4: In a write to offset 0x000, bus_wdata[24] gives a one-clock pulse on conv_rst_pulse and bus_wdata[25] gives a one-clock pulse on tcnt_rst_pulse, both in the ack clock. These bits are not stored, and a read of offset 0x000 shows bits 31:30 as 0.
- R5: A read of offset 0x000 returns {2'b00, fifo_level[5:0], window[23:0]}.
- R6: A read of offset 0x004 returns {20'h0, sw_hi, sw_mid, sw_lo}.
- R7: A read of offset 0x008 returns 0x76543210, and a read of offset 0x00C returns 0x FEDCBA98.
- R8: A read at any offset from 0x800 to 0xFFF with the FIFO not empty drives fifo_pop high in the strobe clock and returns the head word fifo_head.
- R9: A read in the data range while fifo_empty is high returns 0 and does not assert fifo_pop.
- R10: A read of any other offset returns 0 and is still acknowledged.
- R11: fifo_wr_grant equals fifo_wr_req except in a clock where fifo_pop is high, when it is 0.
- R12: If bus_rd and bus_wr are high together, the read is served and the write is ignored.
- R13: After reset the window is 0 and bus_ack, bus_rdata, and both pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one clock |
| bus_rd | input | 1 | Read strobe, one clock |
| bus_rdata | output | 32 | Read data, valid with ack |
| bus_ack | output | 1 | Acknowledge |
| sw_hi | input | 4 | Selector switch for addr[23:20] |
| sw_mid | input | 4 | Selector switch for addr[19:16] |
| sw_lo | input | 4 | Selector switch for addr[15:12] |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_level | input | 6 | Events held in FIFO |
| fifo_head | input | 32 | Show-ahead FIFO head word |
| fifo_pop | output | 1 | Advance FIFO |
| fifo_wr_req | input | 1 | FIFO writer wants to write |
| fifo_wr_grant | output | 1 | Writer may write this clock |
| win_value | output | 24 | Current time window |
| conv_rst_pulse | output | 1 | Converter reset pulse |
| tcnt_rst_pulse | output | 1 | Time counter reset pulse |

## Verification
A vector table walks every mapped offset once under a matching switch setting:
- Each read returns a distinct value, so swapped decode regions show up as wrong data.
- Two reads in the FIFO range sit at its lowest and highest word offsets, which separates range decode from single-address decode.
- Reads of the control register before and after pops check that the level field follows the FIFO.

Directed accesses cover the remaining cases:
- A non-matching board address checks that nothing responds.
- Draining the FIFO dry checks the empty path.
- A control write carrying both reset bits checks the pulses.
- Overlapping strobes check the read-first rule.
- A pop issued while the writer requests checks that the writer loses.

// File: rtl/tdc_regif_pkg.sv
package tdc_regif_pkg;
    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 32;
    localparam int WIN_W   = 24;
    localparam int LVL_W   = 6;
    localparam int SW_W    = 4;
    localparam int SW_N    = 3;
    localparam int OFF_W   = ADDR_W - SW_N * SW_W;
    localparam int CONV_RST_BIT = 24;
    localparam int TCNT_RST_BIT = 25;
    localparam logic [DATA_W-1:0] PATTERN_A = 32'h7654_3210;
    localparam logic [DATA_W-1:0] PATTERN_B = 32'hFEDC_BA98;

    typedef enum logic [2:0] {
        RG_CTRL,
        RG_SWITCH,
        RG_PAT_A,
        RG_PAT_B,
        RG_DATA,
        RG_NONE
    } region_e;

    typedef struct packed {
        logic    hit;
        region_e region;
    } decode_t;

    function automatic region_e classify(input logic [OFF_W-1:0] off);
        if (off[OFF_W-1])          return RG_DATA;
        else if (off == 12'h000)   return RG_CTRL;
        else if (off == 12'h004)   return RG_SWITCH;
        else if (off == 12'h008)   return RG_PAT_A;
        else if (off == 12'h00C)   return RG_PAT_B;
        else                       return RG_NONE;
    endfunction
endpackage

// File: rtl/tdc_addr_decode.sv
module tdc_addr_decode
    import tdc_regif_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr,
    input  logic [SW_N*SW_W-1:0] sw_all,
    output decode_t              dec
);
    logic [SW_N-1:0] nib_match;

    genvar i;
    generate
        for (i = 0; i < SW_N; i++) begin : g_nib
            assign nib_match[i] =
                addr[OFF_W + i*SW_W +: SW_W] == sw_all[i*SW_W +: SW_W];
        end
    endgenerate

    always_comb begin
        dec.hit    = &nib_match;
        dec.region = classify(addr[OFF_W-1:0]);
    end
endmodule

// File: rtl/tdc_ctrl_regs.sv
module tdc_ctrl_regs
    import tdc_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [WIN_W-1:0]  window,
    output logic              conv_rst,
    output logic              tcnt_rst
);
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:TCNT_RST_BIT+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            window   <= '0;
            conv_rst <= 1'b0;
            tcnt_rst <= 1'b0;
        end else begin
            conv_rst <= ctrl_wr & wdata[CONV_RST_BIT];
            tcnt_rst <= ctrl_wr & wdata[TCNT_RST_BIT];
            if (ctrl_wr)
                window <= wdata[WIN_W-1:0];
        end
    end

    // R4: reset strobes last a single clock
    assert_conv_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        conv_rst |=> !conv_rst);
    assert_tcnt_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        tcnt_rst |=> !tcnt_rst);
    // R3: window holds without a control write
    assert_window_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(window));
endmodule

// File: rtl/tdc_read_port.sv
module tdc_read_port
    import tdc_regif_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_sel,
    input  logic                 wr_sel,
    input  region_e              region,
    input  logic [WIN_W-1:0]     window,
    input  logic [LVL_W-1:0]     fifo_level,
    input  logic [SW_N*SW_W-1:0] sw_all,
    input  logic                 fifo_empty,
    input  logic [DATA_W-1:0]    fifo_head,
    input  logic                 fifo_wr_req,
    output logic                 fifo_pop,
    output logic                 fifo_wr_grant,
    output logic [DATA_W-1:0]    rdata,
    output logic                 ack
);
    localparam int PAD_W = DATA_W - LVL_W - WIN_W;
    logic [DATA_W-1:0] rd_mux;

    assign fifo_pop      = rd_sel && region == RG_DATA && !fifo_empty;
    assign fifo_wr_grant = fifo_wr_req & ~fifo_pop;

    always_comb begin
        unique case (region)
            RG_CTRL:   rd_mux = {{PAD_W{1'b0}}, fifo_level, window};
            RG_SWITCH: rd_mux = {{(DATA_W-SW_N*SW_W){1'b0}}, sw_all};
            RG_PAT_A:  rd_mux = PATTERN_A;
            RG_PAT_B:  rd_mux = PATTERN_B;
            RG_DATA:   rd_mux = fifo_empty ? '0 : fifo_head;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack   <= 1'b0;
            rdata <= '0;
        end else begin
            ack   <= rd_sel | wr_sel;
            rdata <= rd_sel ? rd_mux : '0;
        end
    end

    // R9: never pop an empty FIFO
    assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> !fifo_empty);
    // R11: writer is held off while popping
    assert_pop_wins_R11: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> !fifo_wr_grant);
    // R2: ack is a single clock following a selected strobe
    assert_ack_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_sel | wr_sel) |=> ack);
    assert_ack_cause_R2: assert property (@(posedge clk) disable iff (rst)
        !(rd_sel | wr_sel) |=> !ack);
endmodule

// File: rtl/tdc_regif.sv
module tdc_regif
    import tdc_regif_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [23:0] bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    output logic        bus_ack,
    input  logic [3:0]  sw_hi,
    input  logic [3:0]  sw_mid,
    input  logic [3:0]  sw_lo,
    input  logic        fifo_empty,
    input  logic [5:0]  fifo_level,
    input  logic [31:0] fifo_head,
    output logic        fifo_pop,
    input  logic        fifo_wr_req,
    output logic        fifo_wr_grant,
    output logic [23:0] win_value,
    output logic        conv_rst_pulse,
    output logic        tcnt_rst_pulse
);
    logic [SW_N*SW_W-1:0] sw_all;
    decode_t              dec;
    logic                 rd_sel, wr_sel, ctrl_wr;

    assign sw_all  = {sw_hi, sw_mid, sw_lo};
    assign rd_sel  = bus_rd & dec.hit;
    assign wr_sel  = bus_wr & ~bus_rd & dec.hit;
    assign ctrl_wr = wr_sel && dec.region == RG_CTRL;

    tdc_addr_decode u_dec (
        .addr   (bus_addr),
        .sw_all (sw_all),
        .dec    (dec)
    );

    tdc_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .wdata    (bus_wdata),
        .window   (win_value),
        .conv_rst (conv_rst_pulse),
        .tcnt_rst (tcnt_rst_pulse)
    );

    tdc_read_port u_rd (
        .clk           (clk),
        .rst           (rst),
        .rd_sel        (rd_sel),
        .wr_sel        (wr_sel),
        .region        (dec.region),
        .window        (win_value),
        .fifo_level    (fifo_level),
        .sw_all        (sw_all),
        .fifo_empty    (fifo_empty),
        .fifo_head     (fifo_head),
        .fifo_wr_req   (fifo_wr_req),
        .fifo_pop      (fifo_pop),
        .fifo_wr_grant (fifo_wr_grant),
        .rdata         (bus_rdata),
        .ack           (bus_ack)
    );

    // R1: an unselected address never acknowledges
    assert_no_ack_unselected_R1: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd | bus_wr) && !dec.hit) |=> !bus_ack);
    // R12: overlapping strobes leave the window untouched
    assert_read_first_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_wr) |=> $stable(win_value));
endmodule

// File: tb/tdc_regif_test.sv
module tdc_regif_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic [3:0]  sw_hi = 4'hA, sw_mid = 4'hB, sw_lo = 4'hC;
    logic        fifo_pop, fifo_wr_grant;
    logic        fifo_wr_req = 1'b0;
    logic [23:0] win_value;
    logic        conv_rst_pulse, tcnt_rst_pulse;

    // bench FIFO model
    logic [31:0] fmem [4];
    int          fhead = 0;
    int          fcount = 3;
    logic        fifo_empty;
    logic [5:0]  fifo_level;
    logic [31:0] fifo_head;
    assign fifo_empty = (fcount == 0);
    assign fifo_level = fcount[5:0];
    assign fifo_head  = fmem[fhead];

    int checks = 0, failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    always @(posedge clk) if (fifo_pop) begin
        fhead  <= fhead + 1;
        fcount <= fcount - 1;
    end

    tdc_regif uut (.*);

    // {is_write, addr, data-or-expected}
    localparam logic [56:0] VEC [9] = '{
        {1'b1, 24'hABC000, 32'h0012_3456},
        {1'b0, 24'hABC000, 32'h0312_3456},
        {1'b0, 24'hABC004, 32'h0000_0ABC},
        {1'b0, 24'hABC008, 32'h7654_3210},
        {1'b0, 24'hABC00C, 32'hFEDC_BA98},
        {1'b0, 24'hABC800, 32'hA000_0001},
        {1'b0, 24'hABCFFC, 32'hA000_0002},
        {1'b0, 24'hABC010, 32'h0000_0000},
        {1'b0, 24'hABC000, 32'h0112_3456}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic rd, input logic [23:0] a,
                          input logic [31:0] d, output logic [31:0] rv,
                          output logic ackv, output logic popv, output logic [1:0] pulses);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = wr; bus_rd = rd;
        #1 popv = fifo_pop;
        @(negedge clk);
        rv = bus_rdata; ackv = bus_ack; pulses = {tcnt_rst_pulse, conv_rst_pulse};
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [31:0] rv;
        logic ackv, popv;
        logic [1:0] pl;
        fmem[0] = 32'hA000_0001; fmem[1] = 32'hA000_0002;
        fmem[2] = 32'hA000_0003; fmem[3] = 32'h0;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 window", {8'h0, win_value}, 32'h0);
        chk("R13 ack/pulses", {29'h0, bus_ack, conv_rst_pulse, tcnt_rst_pulse}, 32'h0);
        chk("R13 rdata", bus_rdata, 32'h0);
        rst = 1'b0;

        // table walk: R3 R5 R6 R7 R8 R10 R2
        for (int i = 0; i < 9; i++) begin
            access(VEC[i][56], !VEC[i][56], VEC[i][55:32], VEC[i][31:0], rv, ackv, popv, pl);
            chk($sformatf("R2 ack vec%0d", i), {31'h0, ackv}, 32'h1);
            if (!VEC[i][56]) chk($sformatf("R5/R6/R7/R8/R10 data vec%0d", i), rv, VEC[i][31:0]);
            else chk("R3 window load", {8'h0, win_value}, VEC[i][31:0]);
            chk($sformatf("R8 pop vec%0d", i), {31'h0, popv},
                {31'h0, VEC[i][55:32] >= 24'hABC800});
        end

        // R2: ack lasts one clock
        @(negedge clk);
        chk("R2 ack drops", {31'h0, bus_ack}, 32'h0);

        // R4: reset pulses, bits not stored
        access(1'b1, 1'b0, 24'hABC000, 32'hC3AA_5501, rv, ackv, popv, pl);
        chk("R4 pulses high", {30'h0, pl}, 32'h3);
        chk("R2 write rdata zero", rv, 32'h0);
        @(negedge clk);
        chk("R4 pulses cleared", {30'h0, tcnt_rst_pulse, conv_rst_pulse}, 32'h0);
        access(1'b0, 1'b1, 24'hABC000, 32'h0, rv, ackv, popv, pl);
        chk("R4 R5 readback", rv, 32'h01AA_5501);

        // R1: wrong board address
        access(1'b0, 1'b1, 24'h123800, 32'h0, rv, ackv, popv, pl);
        chk("R1 no ack/pop", {30'h0, ackv, popv}, 32'h0);
        access(1'b1, 1'b0, 24'hABB000, 32'h0300_0077, rv, ackv, popv, pl);
        chk("R1 no write ack/pulse", {29'h0, ackv, pl}, 32'h0);
        chk("R1 window unchanged", {8'h0, win_value}, 32'h00AA_5501);

        // R3: write to other offset ignored
        access(1'b1, 1'b0, 24'hABC008, 32'h0300_0011, rv, ackv, popv, pl);
        chk("R3 other offset ack", {29'h0, ackv, pl}, 32'h4);
        chk("R3 other offset no change", {8'h0, win_value}, 32'h00AA_5501);

        // R12: overlapping strobes
        access(1'b1, 1'b1, 24'hABC000, 32'h0300_FFFF, rv, ackv, popv, pl);
        chk("R12 read served", rv, 32'h01AA_5501);
        chk("R12 write ignored", {8'h0, win_value}, 32'h00AA_5501);
        chk("R12 no pulse", {30'h0, pl}, 32'h0);

        // R11: pop beats writer (last FIFO word)
        @(negedge clk);
        fifo_wr_req = 1'b1;
        #1 chk("R11 grant idle", {31'h0, fifo_wr_grant}, 32'h1);
        bus_addr = 24'hABC900; bus_rd = 1'b1;
        #1 chk("R11 grant withheld", {30'h0, fifo_pop, fifo_wr_grant}, 32'h2);
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R8 last word", bus_rdata, 32'hA000_0003);
        #1 chk("R11 grant back", {31'h0, fifo_wr_grant}, 32'h1);
        fifo_wr_req = 1'b0;

        // R9: empty FIFO read
        access(1'b0, 1'b1, 24'hABC800, 32'h0, rv, ackv, popv, pl);
        chk("R9 empty data", rv, 32'h0);
        chk("R9 empty ack no pop", {30'h0, ackv, popv}, 32'h2);
        access(1'b0, 1'b1, 24'hABC000, 32'h0, rv, ackv, popv, pl);
        chk("R5 level zero", rv, 32'h00AA_5501);

        // R6 with other switch setting
        sw_hi = 4'h1; sw_mid = 4'h2; sw_lo = 4'h3;
        access(1'b0, 1'b1, 24'h123004, 32'h0, rv, ackv, popv, pl);
        chk("R6 switches", rv, 32'h0000_0123);

        finish_up();
    end
endmodule